// File: doc/BRIEF.md
# Ethernet Receive Statistics Counters

This block holds three receive-side statistics counters for an Ethernet MAC. The receive path pulses a one-cycle frame-done strobe at the end of every frame and presents a status summary with it: the byte length from the destination address through the FCS, a CRC-good flag, multicast, broadcast and VLAN-tag flags, a range/length-error flag and a flag for a frame that does not end on a whole byte. Each counter applies its own increment rule to that summary. The rules combine a legal-length window with a frame class.

The counters are a total-frames counter, a bad-FCS counter and a good-multicast counter. Software reaches them through a word-addressed register port. It can read any counter, and a write loads a new value, so the same write both preloads and clears. Counters wrap to zero on overflow. A software write wins over an increment in the same cycle.

Top module: `rx_frame_stats`

## Requirements
- R1: The total counter (word address 0) increments by one on every frame-done strobe, whatever the status flags and length.
- R2: The FCS counter (word address 1) increments on a strobe only when the CRC-good flag is 0 and the length lies between 64 and 1518 bytes inclusive.
- R3: A frame with the not-whole-byte flag set never increments the FCS counter.
- R4: The multicast counter (word address 2) increments on a strobe only when the multicast and CRC-good flags are 1 and the length is at least 64 and at most 1518, or at most 1522 when the VLAN flag is 1.
- R5: A frame with the broadcast flag or the range/length-error flag set never increments the multicast counter.
- R6: A read returns the addressed counter in the low bits of the data word, with bits 22 and up (total, multicast) or 16 and up (FCS) reading 0. Word addresses other than 0, 1 and 2 read 0, and writes to them change no counter.
- R7: After reset every counter reads 0.
- R8: A write to a counter's address loads the low bits of the write data into that counter. Writing 0 clears it.
- R9: When a write and an increment reach the same counter in the same cycle, the counter takes the written value.
- R10: A counter holding its all-ones value wraps to 0 on its next increment.
- R11: A counter changes by at most one per strobe, and holds its value in cycles with neither a strobe nor a write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fr_done | input | 1 | One-cycle end-of-frame strobe |
| fr_len | input | LEN_W | Frame length in bytes, DA through FCS |
| fr_crc_ok | input | 1 | CRC check passed |
| fr_mcast | input | 1 | Destination is a multicast address |
| fr_bcast | input | 1 | Destination is the broadcast address |
| fr_vlan | input | 1 | Frame carries a VLAN tag |
| fr_len_err | input | 1 | Range or length error detected |
| fr_partial | input | 1 | Frame does not end on a whole byte |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from the address |

## Verification
The bench builds the block with a 5-bit total counter, a 4-bit FCS counter and a 5-bit multicast counter and keeps the default length window. With these widths the counters wrap every few dozen frames, so the overflow path is exercised many times during a sweep of all 64 status-flag combinations at each length near the 64, 1518 and 1522 boundaries. After every frame the bench reads all three counters and compares them with an arithmetic model. It also preloads all-ones values, sends a write and a strobe in the same cycle, and reads and writes unmapped addresses.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  localparam int unsigned DATA_W = 32;

  typedef enum logic [1:0] {
    SEL_TOTAL = 2'd0,
    SEL_FCS   = 2'd1,
    SEL_MCAST = 2'd2,
    SEL_NONE  = 2'd3
  } rxs_sel_e;

  // inclusive window test on a byte count
  function automatic logic len_between(input int unsigned len,
                                       input int unsigned lo,
                                       input int unsigned hi);
    return (len >= lo) && (len <= hi);
  endfunction

  // upper legal length, widened for tagged frames
  function automatic int unsigned len_ceiling(input logic tagged_fr,
                                              input int unsigned plain_max,
                                              input int unsigned tag_max);
    return tagged_fr ? tag_max : plain_max;
  endfunction

endpackage

// File: rtl/rxs_classify.sv
module rxs_classify
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned TAG_MAX = 1522
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fr_done,
  input  logic [LEN_W-1:0] fr_len,
  input  logic             fr_crc_ok,
  input  logic             fr_mcast,
  input  logic             fr_bcast,
  input  logic             fr_vlan,
  input  logic             fr_len_err,
  input  logic             fr_partial,
  output logic             inc_total,
  output logic             inc_fcs,
  output logic             inc_mcast
);

  int unsigned len_u;
  logic        len_std_ok;
  logic        len_mc_ok;
  logic        mc_class_ok;

  always_comb begin
    len_u       = int'(fr_len);
    len_std_ok  = len_between(len_u, MIN_LEN, MAX_LEN);
    len_mc_ok   = len_between(len_u, MIN_LEN, len_ceiling(fr_vlan, MAX_LEN, TAG_MAX));
    mc_class_ok = fr_mcast && !fr_bcast && !fr_len_err;
  end

  assign inc_total = fr_done;
  assign inc_fcs   = fr_done && !fr_crc_ok && !fr_partial && len_std_ok;
  assign inc_mcast = fr_done && fr_crc_ok && mc_class_ok && len_mc_ok;

  // the two filtered counters split on CRC status
  assert_fcs_mc_disjoint_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(inc_fcs && inc_mcast));
  // filtered increments only come with a counted frame
  assert_fcs_in_total_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_fcs |-> inc_total);
  assert_mc_in_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    inc_mcast |-> inc_total);
  assert_partial_blocks_fcs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fr_partial |-> !inc_fcs);
  assert_bcast_blocks_mc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_bcast || fr_len_err) |-> !inc_mcast);

endmodule

// File: rtl/rxs_counter.sv
module rxs_counter #(
  parameter int unsigned CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] q
);

  logic [CNT_W-1:0] q_next;
  logic             at_top;

  assign at_top = &q;

  always_comb begin
    q_next = q;
    if (wr)       q_next = wdata;
    else if (inc) q_next = q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));
  assert_single_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && !at_top) |=> q == $past(q) + CNT_W'(1));
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !wr && at_top) |=> q == '0);
  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !wr) |=> $stable(q));

endmodule

// File: rtl/rxs_regport.sv
module rxs_regport
  import rxs_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned TOT_W  = 22,
  parameter int unsigned FCS_W  = 16,
  parameter int unsigned MC_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [TOT_W-1:0]  tot_q,
  input  logic [FCS_W-1:0]  fcs_q,
  input  logic [MC_W-1:0]   mc_q,
  output logic              wr_total,
  output logic              wr_fcs,
  output logic              wr_mcast,
  output logic [DATA_W-1:0] reg_rdata
);

  rxs_sel_e sel;

  always_comb begin
    if      (reg_addr == ADDR_W'(0)) sel = SEL_TOTAL;
    else if (reg_addr == ADDR_W'(1)) sel = SEL_FCS;
    else if (reg_addr == ADDR_W'(2)) sel = SEL_MCAST;
    else                             sel = SEL_NONE;
  end

  assign wr_total = reg_wr && (sel == SEL_TOTAL);
  assign wr_fcs   = reg_wr && (sel == SEL_FCS);
  assign wr_mcast = reg_wr && (sel == SEL_MCAST);

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_TOTAL: reg_rdata[TOT_W-1:0] = tot_q;
      SEL_FCS:   reg_rdata[FCS_W-1:0] = fcs_q;
      SEL_MCAST: reg_rdata[MC_W-1:0]  = mc_q;
      default:   reg_rdata = '0;
    endcase
  end

  assert_one_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_total, wr_fcs, wr_mcast}));
  assert_fcs_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(1)) |-> reg_rdata[DATA_W-1:FCS_W] == '0);
  assert_unmapped_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr > ADDR_W'(2)) |-> reg_rdata == '0);

endmodule

// File: rtl/rx_frame_stats.sv
module rx_frame_stats
  import rxs_pkg::*;
#(
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned TOT_W   = 22,
  parameter int unsigned FCS_W   = 16,
  parameter int unsigned MC_W    = 22,
  parameter int unsigned MIN_LEN = 64,
  parameter int unsigned MAX_LEN = 1518,
  parameter int unsigned TAG_MAX = 1522
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fr_done,
  input  logic [LEN_W-1:0]  fr_len,
  input  logic              fr_crc_ok,
  input  logic              fr_mcast,
  input  logic              fr_bcast,
  input  logic              fr_vlan,
  input  logic              fr_len_err,
  input  logic              fr_partial,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata
);

  logic             inc_total, inc_fcs, inc_mcast;
  logic             wr_total, wr_fcs, wr_mcast;
  logic [TOT_W-1:0] tot_q;
  logic [FCS_W-1:0] fcs_q;
  logic [MC_W-1:0]  mc_q;

  rxs_classify #(
    .LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN), .TAG_MAX(TAG_MAX)
  ) u_classify (
    .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_len(fr_len),
    .fr_crc_ok(fr_crc_ok), .fr_mcast(fr_mcast), .fr_bcast(fr_bcast),
    .fr_vlan(fr_vlan), .fr_len_err(fr_len_err), .fr_partial(fr_partial),
    .inc_total(inc_total), .inc_fcs(inc_fcs), .inc_mcast(inc_mcast)
  );

  rxs_counter #(.CNT_W(TOT_W)) u_cnt_total (
    .clk(clk), .rst_n(rst_n), .inc(inc_total), .wr(wr_total),
    .wdata(reg_wdata[TOT_W-1:0]), .q(tot_q)
  );

  rxs_counter #(.CNT_W(FCS_W)) u_cnt_fcs (
    .clk(clk), .rst_n(rst_n), .inc(inc_fcs), .wr(wr_fcs),
    .wdata(reg_wdata[FCS_W-1:0]), .q(fcs_q)
  );

  rxs_counter #(.CNT_W(MC_W)) u_cnt_mcast (
    .clk(clk), .rst_n(rst_n), .inc(inc_mcast), .wr(wr_mcast),
    .wdata(reg_wdata[MC_W-1:0]), .q(mc_q)
  );

  rxs_regport #(
    .ADDR_W(ADDR_W), .TOT_W(TOT_W), .FCS_W(FCS_W), .MC_W(MC_W)
  ) u_regport (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .tot_q(tot_q), .fcs_q(fcs_q), .mc_q(mc_q),
    .wr_total(wr_total), .wr_fcs(wr_fcs), .wr_mcast(wr_mcast),
    .reg_rdata(reg_rdata)
  );

  // a strobe with no write always moves the total counter
  assert_total_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && !wr_total) |=> tot_q != $past(tot_q));

endmodule

// File: tb/test_rx_frame_stats.sv
module test_rx_frame_stats;

  localparam int TOT_W  = 5;
  localparam int FCS_W  = 4;
  localparam int MC_W   = 5;
  localparam int LEN_W  = 14;
  localparam int ADDR_W = 4;
  localparam realtime CLK_HALF = 4ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              fr_done = 1'b0;
  logic [LEN_W-1:0]  fr_len = '0;
  logic              fr_crc_ok = 1'b0, fr_mcast = 1'b0, fr_bcast = 1'b0;
  logic              fr_vlan = 1'b0, fr_len_err = 1'b0, fr_partial = 1'b0;
  logic              reg_wr = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;

  int n_checks = 0;
  int n_fail   = 0;
  int m_tot = 0, m_fcs = 0, m_mc = 0;

  always #(CLK_HALF) clk = ~clk;

  rx_frame_stats #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .TOT_W(TOT_W), .FCS_W(FCS_W), .MC_W(MC_W)
  ) i_rx_frame_stats (
    .clk(clk), .rst_n(rst_n), .fr_done(fr_done), .fr_len(fr_len),
    .fr_crc_ok(fr_crc_ok), .fr_mcast(fr_mcast), .fr_bcast(fr_bcast),
    .fr_vlan(fr_vlan), .fr_len_err(fr_len_err), .fr_partial(fr_partial),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  function automatic int wmask(input int w);
    return (1 << w) - 1;
  endfunction

  task automatic check_rd(input int addr, input int exp, input string tag);
    reg_addr = ADDR_W'(addr);
    #1;
    n_checks++;
    if (reg_rdata !== 32'(exp)) begin
      n_fail++;
      $display("FAIL %s addr %0d: actual 0x%08h expected 0x%08h", tag, addr, reg_rdata, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check_rd(0, m_tot, {tag, " R1"});
    check_rd(1, m_fcs, {tag, " R2 R3"});
    check_rd(2, m_mc,  {tag, " R4 R5"});
  endtask

  // model of the counting rules, written from the requirements
  task automatic model_frame(input int len, input logic [5:0] f);
    logic crc, mc, bc, vl, le, pt;
    int   ceil;
    {pt, le, vl, bc, mc, crc} = f;
    ceil = vl ? 1522 : 1518;
    m_tot = (m_tot + 1) & wmask(TOT_W);
    if (!crc && !pt && len >= 64 && len <= 1518)
      m_fcs = (m_fcs + 1) & wmask(FCS_W);
    if (mc && crc && !bc && !le && len >= 64 && len <= ceil)
      m_mc = (m_mc + 1) & wmask(MC_W);
  endtask

  task automatic drive_frame(input int len, input logic [5:0] f);
    @(negedge clk);
    fr_len = LEN_W'(len);
    {fr_partial, fr_len_err, fr_vlan, fr_bcast, fr_mcast, fr_crc_ok} = f;
    fr_done = 1'b1;
    @(negedge clk);
    fr_done = 1'b0;
    model_frame(len, f);
  endtask

  task automatic reg_write(input int addr, input logic [31:0] data);
    @(negedge clk);
    reg_addr = ADDR_W'(addr);
    reg_wdata = data;
    reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    case (addr)
      0: m_tot = int'(data) & wmask(TOT_W);
      1: m_fcs = int'(data) & wmask(FCS_W);
      2: m_mc  = int'(data) & wmask(MC_W);
      default: ;
    endcase
  endtask

  initial begin
    #(CLK_HALF * 2 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int lens [13] = '{0, 63, 64, 65, 1000, 1517, 1518, 1519, 1520, 1521, 1522, 1523, 2000};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R7 reset values
    check_rd(0, 0, "R7");
    check_rd(1, 0, "R7");
    check_rd(2, 0, "R7");

    // R6 R8 preload all ones: only the low bits are stored
    reg_write(0, 32'hFFFF_FFFF);
    reg_write(1, 32'hFFFF_FFFF);
    reg_write(2, 32'hFFFF_FFFF);
    check_all("R6 R8 preload");

    // R10 wrap: bad-CRC frame wraps total and FCS, then good multicast wraps mcast
    drive_frame(100, 6'b000000);
    check_all("R10 wrap a");
    drive_frame(100, 6'b000011);
    check_all("R10 wrap b");

    // R8 clear
    reg_write(0, 32'h0);
    reg_write(1, 32'h0);
    reg_write(2, 32'h0);
    check_all("R8 clear");

    // R11 flags toggling without a strobe change nothing
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      {fr_partial, fr_len_err, fr_vlan, fr_bcast, fr_mcast, fr_crc_ok} = 6'(k * 9);
      fr_len = LEN_W'(64 + k);
    end
    @(negedge clk);
    check_all("R11 no strobe");

    // R1..R5 sweep of every flag combination at the window edges
    foreach (lens[i]) begin
      for (int f = 0; f < 64; f++) begin
        drive_frame(lens[i], 6'(f));
        check_all($sformatf("sweep len %0d flags %0d", lens[i], f));
      end
    end

    // R9 write and increment in the same cycle
    @(negedge clk);
    fr_len = LEN_W'(200);
    {fr_partial, fr_len_err, fr_vlan, fr_bcast, fr_mcast, fr_crc_ok} = 6'b000011;
    fr_done = 1'b1;
    reg_wr = 1'b1;
    reg_addr = ADDR_W'(2);
    reg_wdata = 32'd7;
    @(negedge clk);
    fr_done = 1'b0;
    reg_wr = 1'b0;
    m_tot = (m_tot + 1) & wmask(TOT_W);
    m_mc = 7;
    check_all("R9 write priority");

    // R6 unmapped addresses read zero and ignore writes
    reg_write(3, 32'hFFFF_FFFF);
    reg_write(15, 32'h0000_0005);
    check_rd(3, 0, "R6 unmapped");
    check_rd(15, 0, "R6 unmapped");
    check_all("R6 unmapped write");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule